// File: doc/BRIEF.md
# Conversion Queue Scan Sequencer

This block runs a list of conversion command words, one after another, from a small local command store. Each command word names a converter channel and may also carry a pause marker or an end-of-list marker. For each word the sequencer sends a one-cycle start request with the channel number to an external converter. It then waits for the converter's done pulse before it moves on.

A scan is armed by a single-scan enable bit. What starts the scan depends on the mode. In software mode the scan starts as soon as the bit is set. In edge mode it waits for a selected edge on the trigger input. In gated mode it waits for a high level on that same input. The pause marker, the end of the list and a gate that closes early are each handled according to the mode. The block reports completion, pause and trigger-overrun flags, and it exposes the index of the current command word. A control write selects the mode, the edge polarity and the enable bit. A write port loads the command store.

Top module: `scan_queue_seq`

## Requirements
- R1: After reset the block is idle: no start request, the enable bit is 0, all three flags are 0 and the command index is 0.
- R2: A command word is CHAN_W+2 bits wide: bit CHAN_W+1 marks end of list, bit CHAN_W marks pause, and the low CHAN_W bits are the channel. When a scan starts from idle, the command index restarts at 0. For each word in order, the block raises conv_start for exactly one cycle with that word's channel, then waits for conv_done.
- R3: A scan ends after the word that carries the end marker, or after the last entry of the store. At that point the completion flag is set, the enable bit is cleared, the index stays on the final word, and no further start is issued until the enable bit is written to 1 again.
- R4: Mode encoding is 0 for software, 1 for edge and 2 for gated. In software mode, writing the enable bit to 1 starts the scan. A pause marker sets the pause flag, but the next word is still issued without waiting. A pause marker on the word that ends the list has no effect.
- R5: In software mode the overrun flag is never set, even when the trigger input toggles.
- R6: In edge mode, ctl_pol=1 selects rising edges and ctl_pol=0 selects falling edges. An edge that arrives while the enable bit is 0 starts nothing. The trigger input passes through two synchronizing flops before edge detection.
- R7: In edge mode, a pause marker sets the pause flag and holds the sequencer after that word. The index then points at the next word. The next qualifying edge resumes the scan from that word.
- R8: In edge mode, a qualifying edge that arrives while a word is being issued or converted sets the overrun flag. It does not restart the list.
- R9: In gated mode, a high synchronized trigger level opens the gate and starts the scan. Pause markers are ignored and do not set the pause flag. Completion sets the completion flag and clears the enable bit.
- R10: In gated mode, if the gate is low when a word's done arrives, that word's conversion counts and the scan stops. The enable bit is cleared, the pause flag is set, and the index stays on that word. This rule takes priority over end-of-list completion.
- R11: Each bit of flag_clr clears one flag: bit 0 clears completion, bit 1 clears pause, bit 2 clears overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command store write strobe |
| cmd_addr | input | $clog2(DEPTH) | Command store write index |
| cmd_wdata | input | CHAN_W+2 | Command word to write |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Start mode (0 software, 1 edge, 2 gated) |
| ctl_pol | input | 1 | Edge polarity (1 rising, 0 falling) |
| ctl_sse | input | 1 | Single-scan enable value to write |
| flag_clr | input | 3 | Flag clear strobes (cf, pf, ovr) |
| trig_in | input | 1 | Asynchronous trigger or gate input |
| conv_done | input | 1 | Converter finished the current word |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | CHAN_W | Channel of the current word |
| scan_active | output | 1 | Scan in progress, including a held pause |
| sse | output | 1 | Single-scan enable bit |
| ccw_ptr | output | $clog2(DEPTH) | Current command index |
| flag_cf | output | 1 | Completion flag |
| flag_pf | output | 1 | Pause flag |
| flag_ovr | output | 1 | Trigger overrun flag |

## Verification
The case of interest is a gate that closes on the final word: the done for the last word arrives while the synchronized gate is already low. The end-of-list rule and the gate-close rule then apply in the same cycle. The bench runs a two-word list with a slow converter and drops the gate just after the second start. It then expects the pause flag set, the completion flag clear, the index left on word 1, and exactly two starts. A second case is a trigger edge that lands while a word is being converted. The bench expects the overrun flag to be set with no extra starts and no restart at word 0.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  typedef enum logic [1:0] {
    MODE_SW   = 2'd0,
    MODE_EDGE = 2'd1,
    MODE_GATE = 2'd2
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } scan_st_e;
endpackage

// File: rtl/scanq_cmd_ram.sv
module scanq_cmd_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scanq_trig_sync.sv
module scanq_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= trig_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level = s2_q;
  assign rise  = s2_q & ~prev_q;
  assign fall  = ~s2_q & prev_q;
endmodule

// File: rtl/scanq_seq_fsm.sv
module scanq_seq_fsm
  import scanq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  scan_mode_e    mode,
  input  logic          ctl_we,
  input  logic          ctl_sse,
  input  logic [2:0]    flag_clr,
  input  logic          qual_edge,
  input  logic          gate_lvl,
  input  logic          ccw_eoq,
  input  logic          ccw_pause,
  input  logic          conv_done,
  output scan_st_e      st,
  output logic [AW-1:0] ptr,
  output logic          sse_q,
  output logic          cf_q,
  output logic          pf_q,
  output logic          ovr_q
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  scan_st_e      st_n;
  logic [AW-1:0] ptr_n;
  logic          sse_n, cf_n, pf_n, ovr_n;
  logic          start_ok, is_last;

  always_comb begin
    case (mode)
      MODE_EDGE: start_ok = sse_q & qual_edge;
      MODE_GATE: start_ok = sse_q & gate_lvl;
      default:   start_ok = sse_q;
    endcase
  end

  assign is_last = ccw_eoq | (ptr == LAST_IDX);

  always_comb begin
    st_n  = st;
    ptr_n = ptr;
    sse_n = ctl_we ? ctl_sse : sse_q;
    cf_n  = cf_q  & ~flag_clr[0];
    pf_n  = pf_q  & ~flag_clr[1];
    ovr_n = ovr_q & ~flag_clr[2];
    case (st)
      ST_IDLE: begin
        if (start_ok) begin
          st_n  = ST_ISSUE;
          ptr_n = '0;
        end
      end
      ST_ISSUE: st_n = ST_WAIT;
      ST_WAIT: begin
        if (conv_done) begin
          if (mode == MODE_GATE && !gate_lvl) begin
            st_n  = ST_IDLE;
            sse_n = 1'b0;
            pf_n  = 1'b1;
          end else if (is_last) begin
            st_n  = ST_IDLE;
            sse_n = 1'b0;
            cf_n  = 1'b1;
          end else begin
            ptr_n = ptr + 1'b1;
            st_n  = ST_ISSUE;
            if (ccw_pause && mode != MODE_GATE) begin
              pf_n = 1'b1;
              if (mode == MODE_EDGE) st_n = ST_HOLD;
            end
          end
        end
      end
      ST_HOLD: begin
        if (qual_edge) st_n = ST_ISSUE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (mode == MODE_EDGE && qual_edge && (st == ST_ISSUE || st == ST_WAIT))
      ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      ptr   <= '0;
      sse_q <= 1'b0;
      cf_q  <= 1'b0;
      pf_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      st    <= st_n;
      ptr   <= ptr_n;
      sse_q <= sse_n;
      cf_q  <= cf_n;
      pf_q  <= pf_n;
      ovr_q <= ovr_n;
    end
  end
endmodule

// File: rtl/scan_queue_seq.sv
module scan_queue_seq
  import scanq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CHAN_W = 6,
  localparam int AW    = $clog2(DEPTH),
  localparam int CCW_W = CHAN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [CCW_W-1:0]  cmd_wdata,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_mode,
  input  logic              ctl_pol,
  input  logic              ctl_sse,
  input  logic [2:0]        flag_clr,
  input  logic              trig_in,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              scan_active,
  output logic              sse,
  output logic [AW-1:0]     ccw_ptr,
  output logic              flag_cf,
  output logic              flag_pf,
  output logic              flag_ovr
);
  scan_mode_e       mode_q;
  logic             pol_q;
  scan_st_e         seq_st;
  logic [CCW_W-1:0] ccw;
  logic             trg_lvl, trg_rise, trg_fall, qual_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SW;
      pol_q  <= 1'b1;
    end else if (ctl_we) begin
      mode_q <= scan_mode_e'(ctl_mode);
      pol_q  <= ctl_pol;
    end
  end

  scanq_cmd_ram #(.DEPTH(DEPTH), .WIDTH(CCW_W)) u_ram (
    .clk   (clk),
    .we    (cmd_we),
    .waddr (cmd_addr),
    .wdata (cmd_wdata),
    .raddr (ccw_ptr),
    .rdata (ccw)
  );

  scanq_trig_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .level   (trg_lvl),
    .rise    (trg_rise),
    .fall    (trg_fall)
  );

  assign qual_edge = pol_q ? trg_rise : trg_fall;

  scanq_seq_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .ctl_we    (ctl_we),
    .ctl_sse   (ctl_sse),
    .flag_clr  (flag_clr),
    .qual_edge (qual_edge),
    .gate_lvl  (trg_lvl),
    .ccw_eoq   (ccw[CCW_W-1]),
    .ccw_pause (ccw[CCW_W-2]),
    .conv_done (conv_done),
    .st        (seq_st),
    .ptr       (ccw_ptr),
    .sse_q     (sse),
    .cf_q      (flag_cf),
    .pf_q      (flag_pf),
    .ovr_q     (flag_ovr)
  );

  assign conv_start  = (seq_st == ST_ISSUE);
  assign conv_chan   = ccw[CHAN_W-1:0];
  assign scan_active = (seq_st != ST_IDLE);
endmodule

// File: rtl/scan_queue_seq_chk.sv
module scan_queue_seq_chk
  import scanq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input scan_mode_e mode_q,
  input scan_st_e   seq_st,
  input logic       qual_edge,
  input logic       trg_lvl,
  input logic       conv_start,
  input logic       conv_done,
  input logic       scan_active,
  input logic       sse,
  input logic       flag_pf,
  input logic       flag_ovr
);
  // R2: a start request lasts one cycle
  a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R3: a scan that ends leaves the enable bit cleared
  a_r3_end_clears_sse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_active) |-> !sse);

  // R5: overrun cannot arise in software mode
  a_r5_no_ovr_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SW && !flag_ovr) |=> !flag_ovr);

  // R6: no start while disarmed and idle
  a_r6_no_start_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == ST_IDLE && !sse) |=> !conv_start);

  // R8: an edge during execution records overrun
  a_r8_edge_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EDGE && qual_edge && (seq_st == ST_ISSUE || seq_st == ST_WAIT))
    |=> flag_ovr);

  // R10: gate closed at done stops the scan as a pause
  a_r10_gate_close: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == ST_WAIT && conv_done && mode_q == MODE_GATE && !trg_lvl)
    |=> (!scan_active && flag_pf && !sse));
endmodule

bind scan_queue_seq scan_queue_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_q      (mode_q),
  .seq_st      (seq_st),
  .qual_edge   (qual_edge),
  .trg_lvl     (trg_lvl),
  .conv_start  (conv_start),
  .conv_done   (conv_done),
  .scan_active (scan_active),
  .sse         (sse),
  .flag_pf     (flag_pf),
  .flag_ovr    (flag_ovr)
);

// File: tb/tb_scan_queue_seq.sv
module tb_scan_queue_seq;
  localparam int DEPTH  = 16;
  localparam int CHAN_W = 6;
  localparam int AW     = $clog2(DEPTH);
  localparam int CCW_W  = CHAN_W + 2;
  localparam int NROW   = 6;

  // row: mode[16:15] eoq[14:11] pause[10:7] count[6:2] cf[1] pf[0]; 15 = no marker
  localparam logic [16:0] TBL [NROW] = '{
    {2'd0, 4'd3,  4'd15, 5'd4,  1'b1, 1'b0},
    {2'd0, 4'd5,  4'd2,  5'd6,  1'b1, 1'b1},
    {2'd0, 4'd0,  4'd15, 5'd1,  1'b1, 1'b0},
    {2'd0, 4'd15, 4'd15, 5'd16, 1'b1, 1'b0},
    {2'd2, 4'd4,  4'd1,  5'd5,  1'b1, 1'b0},
    {2'd0, 4'd6,  4'd6,  5'd7,  1'b1, 1'b0}
  };

  logic              clk, rst_n;
  logic              cmd_we, ctl_we, ctl_pol, ctl_sse, trig_in, conv_done;
  logic [AW-1:0]     cmd_addr;
  logic [CCW_W-1:0]  cmd_wdata;
  logic [1:0]        ctl_mode;
  logic [2:0]        flag_clr;
  logic              conv_start, scan_active, sse, flag_cf, flag_pf, flag_ovr;
  logic [CHAN_W-1:0] conv_chan;
  logic [AW-1:0]     ccw_ptr;

  int errors = 0;
  int checks = 0;
  int dly    = 2;
  int busy   = 0;
  int nlog   = 0;
  logic [CHAN_W-1:0] chlog [512];

  scan_queue_seq #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) dut (
    .clk (clk), .rst_n (rst_n), .cmd_we (cmd_we), .cmd_addr (cmd_addr),
    .cmd_wdata (cmd_wdata), .ctl_we (ctl_we), .ctl_mode (ctl_mode),
    .ctl_pol (ctl_pol), .ctl_sse (ctl_sse), .flag_clr (flag_clr),
    .trig_in (trig_in), .conv_done (conv_done), .conv_start (conv_start),
    .conv_chan (conv_chan), .scan_active (scan_active), .sse (sse),
    .ccw_ptr (ccw_ptr), .flag_cf (flag_cf), .flag_pf (flag_pf),
    .flag_ovr (flag_ovr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // converter model: done pulse dly cycles after a start
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      busy <= dly;
      chlog[nlog] <= conv_chan;
      nlog <= nlog + 1;
    end else if (busy > 0) begin
      busy <= busy - 1;
      if (busy == 1) conv_done <= 1'b1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_q(int eoq, int pse);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      cmd_we    = 1'b1;
      cmd_addr  = AW'(i);
      cmd_wdata = {(i == eoq && eoq != 15), (i == pse && pse != 15), CHAN_W'(i + 8)};
    end
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wr_ctl(int mode, logic pol, logic s);
    @(negedge clk);
    ctl_we = 1'b1; ctl_mode = 2'(mode); ctl_pol = pol; ctl_sse = s;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  task automatic wait_idle();
    int t = 0;
    cyc(3);
    while (scan_active && t < 5000) begin
      cyc(1);
      t++;
    end
    if (t >= 5000) chk("R3 scan never ended", 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; cmd_we = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    ctl_we = 1'b0; ctl_mode = 2'd0; ctl_pol = 1'b1; ctl_sse = 1'b0;
    flag_clr = 3'b000; trig_in = 1'b0;
    cyc(4);
    // R1 reset state
    chk("R1 conv_start", int'(conv_start), 0);
    chk("R1 sse", int'(sse), 0);
    chk("R1 flags", int'({flag_cf, flag_pf, flag_ovr}), 0);
    chk("R1 ptr", int'(ccw_ptr), 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 idle after release", int'(scan_active), 0);

    // table-driven software and gated runs (R2 R3 R4 R9)
    for (int r = 0; r < NROW; r++) begin
      logic [16:0] row;
      row = TBL[r];
      clr_flags();
      load_q(int'(row[14:11]), int'(row[10:7]));
      dly = 2 + r;
      trig_in = (row[16:15] == 2'd2);
      base = nlog;
      wr_ctl(int'(row[16:15]), 1'b1, 1'b1);
      wait_idle();
      chk("R2 start count", nlog - base, int'(row[6:2]));
      for (int k = 0; k < int'(row[6:2]); k++)
        chk("R2 channel order", int'(chlog[base + k]), k + 8);
      chk("R3 completion flag", int'(flag_cf), int'(row[1]));
      chk("R4 R9 pause flag", int'(flag_pf), int'(row[0]));
      chk("R3 sse cleared", int'(sse), 0);
      chk("R3 ptr on last word", int'(ccw_ptr), int'(row[6:2]) - 1);
      chk("R5 no overrun", int'(flag_ovr), 0);
      trig_in = 1'b0;
    end

    // R3: stays idle until re-armed
    base = nlog;
    cyc(20);
    chk("R3 no start while idle", nlog - base, 0);

    // R6: edge ignored when disarmed
    clr_flags();
    load_q(2, 1);
    dly = 2;
    wr_ctl(1, 1'b1, 1'b0);
    base = nlog;
    trig_in = 1'b1; cyc(3); trig_in = 1'b0; cyc(10);
    chk("R6 disarmed edge no start", nlog - base, 0);

    // R7: pause holds until next edge
    wr_ctl(1, 1'b1, 1'b1);
    cyc(3);
    trig_in = 1'b1; cyc(25);
    chk("R7 starts before hold", nlog - base, 2);
    chk("R7 held active", int'(scan_active), 1);
    chk("R7 pause flag", int'(flag_pf), 1);
    chk("R7 ptr at next word", int'(ccw_ptr), 2);
    trig_in = 1'b0; cyc(5);
    trig_in = 1'b1;
    wait_idle();
    chk("R7 resumed count", nlog - base, 3);
    chk("R7 resumed channel", int'(chlog[base + 2]), 10);
    chk("R7 completion", int'(flag_cf), 1);
    chk("R8 no overrun from resume edge", int'(flag_ovr), 0);

    // R8: edge while converting
    clr_flags();
    trig_in = 1'b0;
    load_q(3, 15);
    dly = 30;
    wr_ctl(1, 1'b1, 1'b1);
    base = nlog;
    cyc(5);
    trig_in = 1'b1; cyc(10);
    trig_in = 1'b0; cyc(5);
    trig_in = 1'b1;
    wait_idle();
    chk("R8 overrun flag", int'(flag_ovr), 1);
    chk("R8 no restart count", nlog - base, 4);
    chk("R8 first channel", int'(chlog[base]), 8);

    // R6: falling polarity
    clr_flags();
    dly = 2;
    trig_in = 1'b1;
    cyc(5);
    wr_ctl(1, 1'b0, 1'b1);
    base = nlog;
    cyc(6);
    chk("R6 no start without falling edge", nlog - base, 0);
    trig_in = 1'b0;
    wait_idle();
    chk("R6 falling edge run", nlog - base, 4);

    // R10: gate closes mid list
    clr_flags();
    load_q(7, 15);
    dly = 8;
    trig_in = 1'b0;
    wr_ctl(2, 1'b1, 1'b1);
    base = nlog;
    cyc(6);
    chk("R9 closed gate no start", nlog - base, 0);
    trig_in = 1'b1;
    for (int t = 0; t < 200 && (nlog - base) < 3; t++) cyc(1);
    trig_in = 1'b0;
    wait_idle();
    chk("R10 starts before close", nlog - base, 3);
    chk("R10 ptr kept", int'(ccw_ptr), 2);
    chk("R10 pause flag", int'(flag_pf), 1);
    chk("R10 no completion", int'(flag_cf), 0);
    chk("R10 sse cleared", int'(sse), 0);

    // R2: index restarts at 0 on new gated scan
    clr_flags();
    dly = 2;
    trig_in = 1'b1;
    base = nlog;
    wr_ctl(2, 1'b1, 1'b1);
    wait_idle();
    chk("R2 restart at word 0", int'(chlog[base]), 8);
    chk("R9 full gated run", nlog - base, 8);
    chk("R9 completion", int'(flag_cf), 1);

    // R10: gate close coincides with last word
    clr_flags();
    load_q(1, 15);
    dly = 8;
    trig_in = 1'b0;
    wr_ctl(2, 1'b1, 1'b1);
    base = nlog;
    trig_in = 1'b1;
    for (int t = 0; t < 200 && (nlog - base) < 2; t++) cyc(1);
    trig_in = 1'b0;
    wait_idle();
    chk("R10 last-word close count", nlog - base, 2);
    chk("R10 last-word close pf", int'(flag_pf), 1);
    chk("R10 last-word close cf", int'(flag_cf), 0);
    chk("R10 last-word close ptr", int'(ccw_ptr), 1);

    // R5: trigger toggles in software mode
    clr_flags();
    load_q(5, 15);
    dly = 4;
    wr_ctl(0, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) begin
      trig_in = ~trig_in;
      cyc(4);
    end
    wait_idle();
    chk("R5 sw overrun stays 0", int'(flag_ovr), 0);
    chk("R4 sw completion", int'(flag_cf), 1);

    // R11: selective flag clear
    @(negedge clk);
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R11 cf cleared", int'(flag_cf), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule